// File: doc/BRIEF.md
# Register-Write Command Sequencer

This block steps through a program of 32-bit commands held in an external command memory and turns them into timed register writes. Execution is strictly linear: no branches, no reads of registers or status. Each command is either a write command, which produces one beat on a write-only register port, or a wait command, which stalls the sequencer for a programmed number of clock cycles. After every write, a programmable post-write delay is inserted automatically. A burst of writes followed by one precise pause therefore needs no separate wait commands.

Software or a surrounding controller loads the command memory and sets the post-write delay. It raises `enable` to run the program from word 0 and lowers it to stop. `halt` freezes the sequencer exactly where it is for debugging. The command memory is a synchronous RAM with one cycle of read latency. It holds its read data while no read is requested.

The write port is a valid-only stream. It has no ready signal, so the register target has no way to apply back-pressure: it must accept every beat in the cycle where `wr_valid` is high. The fetch port follows the same rule. Control pins (`enable`, `halt`, `wr_delay`) and `busy` are plain levels.

Top module: `cmd_seq_top`

## Requirements
- R1: A command with bit 31 = 1 is a write. In the cycle after its fetch, `wr_valid` is high for exactly one cycle. `wr_addr` equals bits [30:24] shifted left by two, giving a byte offset in 0x000..0x1FC. `wr_data` carries bits [23:0] in its low bits, and `wr_data[31:24]` is zero.
- R2: Fetches are one-cycle `mem_rd` pulses. Read data is used in the following cycle. `mem_addr` advances by one word per command, and the first fetch after `enable` rises is at address 0.
- R3: After a write, the next `mem_rd` follows the write beat by `wr_delay`+1 cycles, so fetch-to-fetch spacing is `wr_delay`+2. With `wr_delay` = 0, the next fetch is in the cycle right after the write beat.
- R4: A command with bits [31:30] = 00 is a wait with a count C in bits [29:0]. The next fetch comes max(C,1)+2 cycles after the wait's own fetch, so a count of zero behaves as one idle cycle.
- R5: The post-write delay is never applied after a wait command: wait timing is independent of `wr_delay`.
- R6: A command with bits [31:30] = 01 produces no write and no pause. The next fetch comes 2 cycles after its own fetch.
- R7: While `halt` is high, no fetch and no write beat is issued, and the fetch address, state and counters all hold. Every cycle of halt adds exactly one cycle to the interval in progress.
- R8: When `enable` is low, `mem_rd` and `wr_valid` are low at once, and `busy` is low from the next cycle. Raising `enable` again restarts the program at address 0.
- R9: During and right after reset, `busy`, `mem_rd` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the program while high |
| halt | input | 1 | Freeze all progress while high |
| wr_delay | input | 8 | Cycles inserted after each write beat |
| mem_rd | output | 1 | Command memory read strobe |
| mem_addr | output | 10 | Command memory word address |
| mem_rdata | input | 32 | Command word, valid the cycle after `mem_rd` |
| wr_valid | output | 1 | Register write beat |
| wr_addr | output | 9 | Register byte offset, bits [1:0] zero |
| wr_data | output | 32 | Register write data, top byte zero |
| busy | output | 1 | Sequencer is running (not idle) |

## Verification
The bench targets the timing corners, because an off-by-one error there produces no wrong data, only the wrong spacing between fetches. It checks four cases:
- A wait count of zero: a design that handled it wrongly would hang or underflow into a huge wait instead of idling for one cycle.
- A zero post-write delay: the bench checks that the next fetch follows the write back-to-back and is not pushed by one cycle.
- A wait command run with a non-zero `wr_delay`: this catches a design that also appends the post-write delay after waits.
- The 01 command pattern: a design that treated it as a write would issue a spurious beat.

A halt taken in the middle of a delay must stretch the interval by exactly its length. A wrong design would either skip cycles or fetch while frozen. Disable followed by re-enable must restart at word 0 rather than resume.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_DELAY,
    ST_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_WRITE,
    OP_WAIT,
    OP_SKIP
  } op_kind_e;

endpackage

// File: rtl/cmd_seq_cnt.sv
// Down-counter shared by the post-write delay and the wait command.
module cmd_seq_cnt #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         expire
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // Last counted cycle: the loaded value is always at least one.
  assign expire = (cnt_q == W'(1));

endmodule

// File: rtl/cmd_seq_pc.sv
// Command word pointer.
module cmd_seq_pc #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [AW-1:0] pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc <= '0;
    else if (clear)
      pc <= '0;
    else if (advance)
      pc <= pc + 1'b1;
  end

endmodule

// File: rtl/cmd_seq_decode.sv
// Splits a command word into its kind and fields.
module cmd_seq_decode
  import cmd_seq_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 24,
  localparam int CMD_W = 1 + IDX_W + DATA_W,
  localparam int CNT_W = CMD_W - 2
) (
  input  logic [CMD_W-1:0] cmd,
  output op_kind_e         kind,
  output logic [IDX_W+1:0] addr,
  output logic [CMD_W-1:0] data,
  output logic [CNT_W-1:0] wait_cycles
);

  localparam int IDX_LSB = DATA_W;
  localparam int IDX_MSB = DATA_W + IDX_W - 1;

  logic [CNT_W-1:0] raw_cnt;

  assign raw_cnt = cmd[CNT_W-1:0];

  always_comb begin
    if (cmd[CMD_W-1])
      kind = OP_WRITE;
    else if (cmd[CMD_W-2])
      kind = OP_SKIP;
    else
      kind = OP_WAIT;
  end

  assign addr        = {cmd[IDX_MSB:IDX_LSB], 2'b00};
  assign data        = {{(CMD_W-DATA_W){1'b0}}, cmd[DATA_W-1:0]};
  assign wait_cycles = (raw_cnt == '0) ? CNT_W'(1) : raw_cnt;

endmodule

// File: rtl/cmd_seq_top.sv
// Sequential register-write command engine.
module cmd_seq_top
  import cmd_seq_pkg::*;
#(
  parameter int AW     = 10,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 24,
  parameter int DLY_W  = 8,
  localparam int CMD_W = 1 + IDX_W + DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             halt,
  input  logic [DLY_W-1:0] wr_delay,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [CMD_W-1:0] mem_rdata,
  output logic             wr_valid,
  output logic [IDX_W+1:0] wr_addr,
  output logic [CMD_W-1:0] wr_data,
  output logic             busy
);

  localparam int CNT_W = CMD_W - 2;
  localparam int TMR_W = (CNT_W > DLY_W) ? CNT_W : DLY_W;

  seq_state_e       st_q, st_d;
  op_kind_e         kind;
  logic [CNT_W-1:0] wait_cycles;
  logic [TMR_W-1:0] tmr_load_val;
  logic             tmr_load, tmr_dec, tmr_expire;
  logic             pc_clear, pc_adv;
  logic             run;

  assign run = enable && !halt;

  cmd_seq_decode #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) dec_i (
    .cmd        (mem_rdata),
    .kind       (kind),
    .addr       (wr_addr),
    .data       (wr_data),
    .wait_cycles(wait_cycles)
  );

  cmd_seq_pc #(
    .AW(AW)
  ) pc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (pc_clear),
    .advance(pc_adv),
    .pc     (mem_addr)
  );

  cmd_seq_cnt #(
    .W(TMR_W)
  ) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_load_val),
    .dec     (tmr_dec),
    .expire  (tmr_expire)
  );

  always_comb begin
    st_d         = st_q;
    tmr_load     = 1'b0;
    tmr_load_val = '0;
    tmr_dec      = 1'b0;
    pc_adv       = 1'b0;
    pc_clear     = 1'b0;
    if (!enable) begin
      st_d     = ST_IDLE;
      pc_clear = 1'b1;
    end else if (!halt) begin
      case (st_q)
        ST_IDLE: st_d = ST_FETCH;
        ST_FETCH: begin
          st_d   = ST_EXEC;
          pc_adv = 1'b1;
        end
        ST_EXEC: begin
          case (kind)
            OP_WRITE: begin
              if (wr_delay == '0) begin
                st_d = ST_FETCH;
              end else begin
                st_d         = ST_DELAY;
                tmr_load     = 1'b1;
                tmr_load_val = TMR_W'(wr_delay);
              end
            end
            OP_WAIT: begin
              st_d         = ST_WAIT;
              tmr_load     = 1'b1;
              tmr_load_val = TMR_W'(wait_cycles);
            end
            default: st_d = ST_FETCH;
          endcase
        end
        ST_DELAY, ST_WAIT: begin
          tmr_dec = 1'b1;
          if (tmr_expire) st_d = ST_FETCH;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign mem_rd   = run && (st_q == ST_FETCH);
  assign wr_valid = run && (st_q == ST_EXEC) && (kind == OP_WRITE);
  assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/cmd_seq_chk.sv
// Temporal checks attached to the sequencer top.
module cmd_seq_chk #(
  parameter int AW     = 10,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 24,
  localparam int CMD_W = 1 + IDX_W + DATA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             halt,
  input logic             mem_rd,
  input logic [AW-1:0]    mem_addr,
  input logic             wr_valid,
  input logic [IDX_W+1:0] wr_addr,
  input logic [CMD_W-1:0] wr_data,
  input logic             busy
);

  assert_data_top_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[CMD_W-1:DATA_W] == '0) && (wr_addr[1:0] == 2'b00));

  assert_single_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_no_fetch_with_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && wr_valid));

  assert_start_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && enable && !halt) |-> (mem_rd && mem_addr == '0));

  assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  assert_halt_freezes_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && enable) |=> $stable(mem_addr));

endmodule

bind cmd_seq_top cmd_seq_chk #(
  .AW    (AW),
  .IDX_W (IDX_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .halt    (halt),
  .mem_rd  (mem_rd),
  .mem_addr(mem_addr),
  .wr_valid(wr_valid),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy)
);

// File: tb/cmd_seq_top_tb_top.sv
`timescale 1ns/1ps
module cmd_seq_top_tb_top;

  localparam time CLK_PERIOD = 20ns;
  localparam int  DLY = 3;
  localparam int  NVEC = 8;
  localparam logic [31:0] PARK = 32'h3FFF_FFFF;

  // Program table: command word and expected fetch-to-fetch spacing.
  localparam logic [31:0] VEC_CMD [NVEC] = '{
    32'h8512_3456,  // write idx 5
    32'h0000_0004,  // wait 4
    32'hFFFF_FFFF,  // write idx 0x7F, all data ones
    32'h0000_0000,  // wait 0 -> one idle cycle
    32'h4000_0005,  // 01 pattern: skipped
    32'h8000_0000,  // write idx 0
    32'h81A5_A5A5,  // write idx 1
    32'h0000_0001   // wait 1
  };
  localparam int VEC_GAP [NVEC] = '{DLY+2, 6, DLY+2, 3, 2, DLY+2, DLY+2, 3};

  logic        clk = 1'b0;
  logic        rst_n, enable, halt;
  logic [7:0]  wr_delay;
  logic        mem_rd, wr_valid, busy;
  logic [9:0]  mem_addr;
  logic [31:0] mem_rdata;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;

  logic [31:0] mem [64];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nf = 0;
  int nw = 0;
  int fetch_cyc [64];
  int fetch_adr [64];
  int wr_cyc    [64];
  int wr_adr    [64];
  logic [31:0] wr_dat [64];

  cmd_seq_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .halt     (halt),
    .wr_delay (wr_delay),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
  end

  always @(negedge clk) begin
    if (mem_rd && nf < 64) begin
      fetch_cyc[nf] = cyc;
      fetch_adr[nf] = int'(mem_addr);
      nf = nf + 1;
    end
    if (wr_valid && nw < 64) begin
      wr_cyc[nw] = cyc;
      wr_adr[nw] = int'(wr_addr);
      wr_dat[nw] = wr_data;
      nw = nw + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int base;
    int wbase;
    mem_rdata = '0;
    for (int i = 0; i < 64; i++) mem[i] = (i < NVEC) ? VEC_CMD[i] : PARK;
    rst_n = 1'b0; enable = 1'b0; halt = 1'b0; wr_delay = 8'(DLY);
    @(negedge clk);
    check(!busy, "R9 busy in reset", longint'(busy), 0);
    check(!mem_rd && !wr_valid, "R9 strobes in reset", longint'({mem_rd, wr_valid}), 0);
    step(); step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check(!busy && !mem_rd && !wr_valid, "R9 idle after reset",
          longint'({busy, mem_rd, wr_valid}), 0);

    // Table-driven run of the whole program.
    step();
    enable = 1'b1;
    wait (nf >= NVEC + 1);
    w = 0;
    for (int k = 0; k < NVEC; k++) begin
      check(fetch_adr[k] == k, "R2 fetch address", fetch_adr[k], k);
      check(fetch_cyc[k+1] - fetch_cyc[k] == VEC_GAP[k], "R3/R4/R5/R6 fetch spacing",
            fetch_cyc[k+1] - fetch_cyc[k], VEC_GAP[k]);
      if (VEC_CMD[k][31]) begin
        check(wr_cyc[w] == fetch_cyc[k] + 1, "R1 write beat cycle", wr_cyc[w], fetch_cyc[k] + 1);
        check(wr_adr[w] == int'({VEC_CMD[k][30:24], 2'b00}), "R1 write address",
              wr_adr[w], {VEC_CMD[k][30:24], 2'b00});
        check(wr_dat[w] == {8'h00, VEC_CMD[k][23:0]}, "R1 write data",
              wr_dat[w], {8'h00, VEC_CMD[k][23:0]});
        w++;
      end
    end
    check(nw == w, "R6 no extra write beats", nw, w);

    // Disable stops at once and idles next cycle.
    step();
    enable = 1'b0;
    @(negedge clk);
    check(!mem_rd && !wr_valid, "R8 strobes off when disabled", longint'({mem_rd, wr_valid}), 0);
    step();
    @(negedge clk);
    check(!busy, "R8 busy low after disable", longint'(busy), 0);

    // Halt in the middle of a post-write delay.
    base = nf;
    step();
    enable = 1'b1;
    wait (nf == base + 1);
    check(fetch_adr[base] == 0, "R8 restart at word 0", fetch_adr[base], 0);
    step();  // write beat cycle
    step();  // first delay cycle
    halt = 1'b1;
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      check(!mem_rd && !wr_valid, "R7 no strobes while halted", longint'({mem_rd, wr_valid}), 0);
      step();
    end
    halt = 1'b0;
    wait (nf == base + 2);
    check(fetch_cyc[base+1] - fetch_cyc[base] == DLY + 2 + 4, "R7 halt stretches interval",
          fetch_cyc[base+1] - fetch_cyc[base], DLY + 6);
    check(fetch_adr[base+1] == 1, "R7 address resumes", fetch_adr[base+1], 1);

    // Zero post-write delay.
    step();
    enable = 1'b0;
    step();
    wr_delay = 8'd0;
    base = nf;
    wbase = nw;
    enable = 1'b1;
    wait (nf == base + 2);
    check(wr_cyc[wbase] == fetch_cyc[base] + 1, "R3 zero-delay write beat",
          wr_cyc[wbase], fetch_cyc[base] + 1);
    check(fetch_cyc[base+1] == wr_cyc[wbase] + 1, "R3 zero-delay next fetch",
          fetch_cyc[base+1], wr_cyc[wbase] + 1);
    wait (nf == base + 3);
    check(fetch_cyc[base+2] - fetch_cyc[base+1] == 6, "R5 wait ignores wr_delay",
          fetch_cyc[base+2] - fetch_cyc[base+1], 6);

    step();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule